// File: doc/BRIEF.md
# Masked Device Interrupt Router

The router keeps one entry per device interrupt source. Each entry holds a routing word, which gives a target processor number and an interrupt vector, and a control word, which gives a mask flag and a pending flag. Each source drives a request line into the block. On a clock edge where a source requests and its entry is not masked, the block accepts it. On acceptance it sets the pending flag and sets the source's own mask, so that source stays silent until software unmasks it. It then raises a one-cycle post pulse that carries the stored processor number and vector.

Software reaches the entries through a 64-bit register port with one register every eight bytes. Routing words occupy the low window. Control words occupy a second window that starts at `8 * 2^IDX_W`, where `IDX_W = $clog2(NUM_SRC)`. With the default eight sources, routing entry *i* sits at `0x08*i` and control entry *i* at `0x40 + 0x08*i`. Read data and the access error flag come back one cycle after the request.

The post path is a two-state machine. `ST_IDLE` means no post is on the outputs. `ST_POST` means a post pulse is being driven. There are four transitions:
- `ST_IDLE -> ST_POST` occurs on an accept.
- `ST_POST -> ST_POST` occurs on a back-to-back accept.
- `ST_POST -> ST_IDLE` occurs when there is no accept.
- `ST_IDLE -> ST_IDLE` occurs when the block stays quiet.

Top module: `irq_router`

## Requirements
- R1: After reset every entry reads mask = 1, pending = 0, processor = 0, vector = 0, and `post_valid` and `acc_err` are low.
- R2: A routing write stores data bits 12:8 as the processor number and bits 5:0 as the vector. All other data bits are dropped. A routing read returns `processor << 8 | vector`, with every other bit zero.
- R3: A control read returns the mask in bit 2 and the pending flag in bit 0, with every other bit zero.
- R4: A control write loads the mask from data bit 2. Data bit 1 = 1 clears pending. Data bit 1 = 0 leaves pending unchanged.
- R5: A request from a masked source is ignored. No post is made, and that source's pending and mask stay as they were.
- R6: Accepting a source sets both its mask and its pending flag. On the edge of acceptance the block raises `post_valid` for exactly one cycle, carrying that entry's processor number and vector.
- R7: When several unmasked sources request in the same cycle, only the lowest-numbered one is accepted that cycle. A source still requesting is taken on a later edge.
- R8: The entry index is the register offset shifted right by 3. Bit `IDX_W+3` of the offset selects the control window (1) or the routing window (0).
- R9: An offset that is misaligned, has any bit above bit `IDX_W+3` set, or names an index at or above `NUM_SRC` is unmapped. A read of an unmapped offset returns zero. A write to an unmapped offset changes nothing. Either kind of access raises `acc_err` for one cycle.
- R10: `rd_valid` and `rd_data` appear exactly one cycle after a read request and show the state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | NUM_SRC | Per-source interrupt request, sampled every edge |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 64 | Read data |
| acc_err | output | 1 | One-cycle pulse after an unmapped access |
| post_valid | output | 1 | One-cycle interrupt post |
| post_cpu | output | CPU_W | Target processor of the post |
| post_vec | output | VEC_W | Vector of the post |

## Verification
The inputs are driven on falling edges. An accepted request posts on the very next rising edge, so the bench samples `post_valid`, `post_cpu` and `post_vec` one time unit after that edge. It samples once more one edge later to confirm the pulse has ended. Register reads and the error flag are registered once, so they are sampled one time unit after the edge that captured the request. A second sample one edge later confirms that `acc_err` has dropped. For the simultaneous-request case, requests stay high across two edges and each edge is checked for its own winner.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_POST = 1'b1
    } post_state_e;

    localparam int unsigned CTL_MASK_BIT = 2;
    localparam int unsigned CTL_CLR_BIT  = 1;
    localparam int unsigned CTL_PEND_BIT = 0;
    localparam int unsigned RTE_CPU_LSB  = 8;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_vec,
    output logic [NUM_SRC-1:0] grant_vec,
    output logic               grant_any,
    output logic [IDX_W-1:0]   grant_idx
);
    always_comb begin
        grant_any = 1'b0;
        grant_idx = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (req_vec[k]) begin
                grant_any = 1'b1;
                grant_idx = IDX_W'(k);
            end
        end
        grant_vec = '0;
        if (grant_any) grant_vec[grant_idx] = 1'b1;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec)); // R7
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any |-> ((req_vec & (grant_vec - NUM_SRC'(1))) == '0)); // R7
    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_vec & ~req_vec) == '0)); // R5
endmodule

// File: rtl/irq_entry_table.sv
module irq_entry_table
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned CPU_W   = 5,
    parameter int unsigned VEC_W   = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rte_we,
    input  logic                          ctl_we,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [CPU_W-1:0]              wr_cpu,
    input  logic [VEC_W-1:0]              wr_vec,
    input  logic                          wr_mask,
    input  logic                          wr_clr,
    input  logic [NUM_SRC-1:0]            acc_grant,
    output logic [NUM_SRC-1:0]            mask_q,
    output logic [NUM_SRC-1:0]            pend_q,
    output logic [NUM_SRC-1:0][CPU_W-1:0] cpu_q,
    output logic [NUM_SRC-1:0][VEC_W-1:0] vec_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
        logic sel;
        assign sel = (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[i] <= 1'b1;
                pend_q[i] <= 1'b0;
                cpu_q[i]  <= '0;
                vec_q[i]  <= '0;
            end else begin
                if (rte_we && sel) begin
                    cpu_q[i] <= wr_cpu;
                    vec_q[i] <= wr_vec;
                end
                if (acc_grant[i]) begin
                    mask_q[i] <= 1'b1;
                    pend_q[i] <= 1'b1;
                end else if (ctl_we && sel) begin
                    mask_q[i] <= wr_mask;
                    if (wr_clr) pend_q[i] <= 1'b0;
                end
            end
        end

        AST_ACCEPT_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
            acc_grant[i] |=> (mask_q[i] && pend_q[i])); // R6
        AST_MASKED_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q[i] && !(ctl_we && sel)) |=> $stable(pend_q[i])); // R5
    end
endmodule

// File: rtl/irq_post_fsm.sv
module irq_post_fsm
    import irq_router_pkg::*;
#(
    parameter int unsigned CPU_W = 5,
    parameter int unsigned VEC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [CPU_W-1:0] acc_cpu,
    input  logic [VEC_W-1:0] acc_vec,
    output logic             post_valid,
    output logic [CPU_W-1:0] post_cpu,
    output logic [VEC_W-1:0] post_vec
);
    post_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = acc_valid ? ST_POST : ST_IDLE;
            ST_POST: state_d = acc_valid ? ST_POST : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_cpu <= '0;
            post_vec <= '0;
        end else if (acc_valid) begin
            post_cpu <= acc_cpu;
            post_vec <= acc_vec;
        end
    end

    assign post_valid = (state_q == ST_POST);

    AST_POST_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |-> $past(acc_valid)); // R6
    AST_POST_CARRIES_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (post_valid && post_cpu == $past(acc_cpu) && post_vec == $past(acc_vec))); // R6
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned CPU_W   = 5,
    parameter int unsigned VEC_W   = 6,
    parameter int unsigned ADDR_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] dev_irq,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [63:0]        req_wdata,
    output logic               rd_valid,
    output logic [63:0]        rd_data,
    output logic               acc_err,
    output logic               post_valid,
    output logic [CPU_W-1:0]   post_cpu,
    output logic [VEC_W-1:0]   post_vec
);
    localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int unsigned WIN_BIT = IDX_W + 3;
    localparam int unsigned TOP_LSB = IDX_W + 4;

    logic [NUM_SRC-1:0]            mask_q, pend_q;
    logic [NUM_SRC-1:0][CPU_W-1:0] cpu_q;
    logic [NUM_SRC-1:0][VEC_W-1:0] vec_q;
    logic [NUM_SRC-1:0]            grant_vec;
    logic                          grant_any;
    logic [IDX_W-1:0]              grant_idx;

    logic [IDX_W-1:0] a_idx;
    logic             a_ctl, a_hit;
    logic [63:0]      rd_mux;

    assign a_idx = req_addr[WIN_BIT-1:3];
    assign a_ctl = req_addr[WIN_BIT];
    assign a_hit = (req_addr[2:0] == 3'b000)
                && (req_addr[ADDR_W-1:TOP_LSB] == '0)
                && (32'(a_idx) < NUM_SRC);

    logic unused_wdata;
    assign unused_wdata = ^{req_wdata[63:13], req_wdata[7:6], req_wdata[0]};

    irq_entry_table #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .CPU_W(CPU_W), .VEC_W(VEC_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rte_we    (req_valid && req_write && a_hit && !a_ctl),
        .ctl_we    (req_valid && req_write && a_hit && a_ctl),
        .wr_idx    (a_idx),
        .wr_cpu    (req_wdata[RTE_CPU_LSB +: CPU_W]),
        .wr_vec    (req_wdata[VEC_W-1:0]),
        .wr_mask   (req_wdata[CTL_MASK_BIT]),
        .wr_clr    (req_wdata[CTL_CLR_BIT]),
        .acc_grant (grant_vec),
        .mask_q    (mask_q),
        .pend_q    (pend_q),
        .cpu_q     (cpu_q),
        .vec_q     (vec_q)
    );

    irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vec   (dev_irq & ~mask_q),
        .grant_vec (grant_vec),
        .grant_any (grant_any),
        .grant_idx (grant_idx)
    );

    irq_post_fsm #(.CPU_W(CPU_W), .VEC_W(VEC_W)) u_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (grant_any),
        .acc_cpu    (cpu_q[grant_idx]),
        .acc_vec    (vec_q[grant_idx]),
        .post_valid (post_valid),
        .post_cpu   (post_cpu),
        .post_vec   (post_vec)
    );

    always_comb begin
        rd_mux = '0;
        if (a_hit) begin
            if (a_ctl) begin
                rd_mux[CTL_MASK_BIT] = mask_q[a_idx];
                rd_mux[CTL_PEND_BIT] = pend_q[a_idx];
            end else begin
                rd_mux[RTE_CPU_LSB +: CPU_W] = cpu_q[a_idx];
                rd_mux[VEC_W-1:0]            = vec_q[a_idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            acc_err  <= 1'b0;
        end else begin
            rd_valid <= req_valid && !req_write;
            rd_data  <= (req_valid && !req_write) ? rd_mux : '0;
            acc_err  <= req_valid && !a_hit;
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write)); // R10
    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && rd_valid) |-> (rd_data == 64'd0)); // R9
    AST_ERR_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(req_valid)); // R9
endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
    localparam int NS = 8;
    localparam logic [15:0] CTL = 16'h0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] dev_irq = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rd_valid, acc_err, post_valid;
    logic [63:0] rd_data;
    logic [4:0]  post_cpu;
    logic [5:0]  post_vec;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_router u0 (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .acc_err(acc_err), .post_valid(post_valid), .post_cpu(post_cpu),
        .post_vec(post_vec)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [15:0] a, output logic [63:0] d, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); #1;
        chk("R10 rd_valid one cycle after read", 64'(rd_valid), 64'd1);
        d = rd_data; e = acc_err;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd_expect(input string tag, input logic [15:0] a, input logic [63:0] exp);
        logic [63:0] d; logic e;
        reg_rd(a, d, e);
        chk(tag, d, exp);
    endtask

    task automatic t_reset;
        chk("R1 post_valid low after reset", 64'(post_valid), 64'd0);
        chk("R1 acc_err low after reset", 64'(acc_err), 64'd0);
        for (int i = 0; i < NS; i++) begin
            rd_expect("R1 control reset value", CTL + 16'(8 * i), 64'h4);
            rd_expect("R1 routing reset value", 16'(8 * i), 64'h0);
        end
    endtask

    task automatic t_route_fmt;
        reg_wr(16'h0018, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_expect("R2 routing drops other bits", 16'h0018, 64'h1F3F);
        reg_wr(16'h0018, 64'h0000_0000_0000_092A);
        rd_expect("R2 routing cpu 9 vec 0x2A", 16'h0018, 64'h092A);
    endtask

    task automatic t_masked_ignored;
        @(negedge clk); dev_irq[3] = 1'b1;
        @(posedge clk); #1;
        chk("R5 masked source gives no post", 64'(post_valid), 64'd0);
        @(negedge clk); dev_irq[3] = 1'b0;
        rd_expect("R5 masked source control unchanged", CTL + 16'h18, 64'h4);
    endtask

    task automatic t_accept;
        reg_wr(CTL + 16'h18, 64'h0);
        rd_expect("R4 mask cleared by write", CTL + 16'h18, 64'h0);
        @(negedge clk); dev_irq[3] = 1'b1;
        @(posedge clk); #1;
        chk("R6 post_valid on accept", 64'(post_valid), 64'd1);
        chk("R6 post cpu", 64'(post_cpu), 64'd9);
        chk("R6 post vector", 64'(post_vec), 64'h2A);
        @(posedge clk); #1;
        chk("R6 post is one cycle with request held", 64'(post_valid), 64'd0);
        @(negedge clk); dev_irq[3] = 1'b0;
        rd_expect("R6 R3 mask and pend set", CTL + 16'h18, 64'h5);
    endtask

    task automatic t_ctl_write;
        reg_wr(CTL + 16'h18, 64'h4);
        rd_expect("R4 bit1 zero keeps pend", CTL + 16'h18, 64'h5);
        reg_wr(CTL + 16'h18, 64'h6);
        rd_expect("R4 bit1 one clears pend", CTL + 16'h18, 64'h4);
        reg_wr(CTL + 16'h18, 64'h2);
        rd_expect("R4 R3 unmask with clear", CTL + 16'h18, 64'h0);
        reg_wr(CTL + 16'h18, 64'h4);
    endtask

    task automatic t_priority;
        reg_wr(16'h0008, 64'h0201);
        reg_wr(16'h0028, 64'h0405);
        reg_wr(CTL + 16'h08, 64'h0);
        reg_wr(CTL + 16'h28, 64'h0);
        @(negedge clk); dev_irq[1] = 1'b1; dev_irq[5] = 1'b1;
        @(posedge clk); #1;
        chk("R7 first post valid", 64'(post_valid), 64'd1);
        chk("R7 lowest source first vec", 64'(post_vec), 64'd1);
        chk("R7 lowest source first cpu", 64'(post_cpu), 64'd2);
        @(posedge clk); #1;
        chk("R7 second post valid", 64'(post_valid), 64'd1);
        chk("R7 next source vec", 64'(post_vec), 64'd5);
        chk("R7 next source cpu", 64'(post_cpu), 64'd4);
        @(negedge clk); dev_irq = '0;
        @(posedge clk); #1;
        chk("R7 no further post", 64'(post_valid), 64'd0);
    endtask

    task automatic t_unmapped;
        logic [63:0] d; logic e;
        reg_rd(16'h1000, d, e);
        chk("R9 unmapped read zero", d, 64'd0);
        chk("R9 unmapped read error", 64'(e), 64'd1);
        @(posedge clk); #1;
        chk("R9 error lasts one cycle", 64'(acc_err), 64'd0);
        reg_rd(16'h000C, d, e);
        chk("R9 misaligned read error", 64'(e), 64'd1);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0080; req_wdata = 64'h0;
        @(posedge clk); #1;
        chk("R9 unmapped write error", 64'(acc_err), 64'd1);
        @(negedge clk); req_valid = 1'b0; req_write = 1'b0;
        rd_expect("R9 unmapped write no effect on control 0", CTL, 64'h4);
        rd_expect("R9 unmapped write no effect on routing 0", 16'h0000, 64'h0);
    endtask

    task automatic t_decode;
        reg_wr(16'h0038, 64'h1733);
        reg_wr(CTL + 16'h38, 64'h0);
        rd_expect("R8 routing entry 7", 16'h0038, 64'h1733);
        rd_expect("R8 control entry 7", CTL + 16'h38, 64'h0);
        rd_expect("R8 routing entry 6 untouched", 16'h0030, 64'h0);
        rd_expect("R8 control entry 6 untouched", CTL + 16'h30, 64'h4);
        @(negedge clk); dev_irq[7] = 1'b1;
        @(posedge clk); #1;
        chk("R8 entry 7 posts its vector", 64'(post_vec), 64'h33);
        @(negedge clk); dev_irq[7] = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        t_reset();
        t_route_fmt();
        t_masked_ignored();
        t_accept();
        t_ctl_write();
        t_priority();
        t_unmapped();
        t_decode();
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule